// File: doc/BRIEF.md
# Multichannel looping PCM voice mixer

This block is a wavetable playback engine. It holds a small set of voices. Each voice has its own playback position, step rate, end limit, loop point, memory bank and a pair of left and right volumes. Software programs the voices through a write-only register port with an 8-bit address and 16-bit data. Each voice parameter sits at a fixed offset. The register map fits at most eleven voices, and the default build uses all eleven.

Each pulse on the sample-tick input starts one pass over the voices, in ascending voice order, one voice per clock cycle. For each audible voice the engine drives the integer part of its position on the memory address port and the voice's bank on the bank port. It takes the 8-bit two's-complement sample returned in the same cycle and multiplies it by both volumes. The products go into two 32-bit accumulators, one for each side. The engine then steps the voice's position by its rate and wraps it to the loop point once it reaches the limit. After the last voice, the upper half of each accumulator is loaded into the output registers, and an output strobe is raised for one cycle. The sample memory and the digital-to-analogue stage sit outside the block.

Top module: `pcm_voice_mixer`

## Requirements
- R1: While reset is asserted and after its release, `out_left`, `out_right`, `out_valid` and `mem_rd` are all zero. Reset is an asynchronous active-low input that is released through a two-stage synchronizer. Every voice register resets to zero.
- R2: A write puts the data into a field of voice v (0 to NUM_VOICES-1) at these addresses: position integer at 0x00+v, rate at 0x16+v, limit at 0x21+v, loop start at 0x2C+v, bank at 0x37+v, right volume at 0x42+v and left volume at 0x4D+v. Writes to any other address, such as 0x0B-0x15 or 0x58 and above, change nothing.
- R3: A tick accepted at clock edge k gives one cycle per voice in ascending order after edges k through k+NUM_VOICES-1. In each such cycle an audible voice raises `mem_rd` and drives `mem_addr` equal to the integer part of its position and `mem_bank` equal to its bank register. `mem_data` is sampled in that same cycle.
- R4: Each sample is taken as signed 8-bit and sign-extended. It is multiplied by the signed 16-bit left volume and by the signed 16-bit right volume. Each side's products are summed in 32 bits starting from zero, and bits 31:16 of the sums become `out_left` and `out_right`.
- R5: The position is a 16-bit integer plus an 8-bit fraction. The rate is unsigned 8.8 fixed point, with its low 8 bits fractional. After each fetch the rate is added to the position.
- R6: If the integer part of the stepped position, including any carry past 16 bits, is greater than or equal to the limit, the integer part becomes the loop start. The new fraction is kept.
- R7: A voice whose left and right volumes are both zero is stopped. It makes no fetch, adds nothing to the sums, and its position stays frozen.
- R8: Writing a position register sets the integer part and clears the fraction. The next fetch of that voice then uses the written address.
- R9: A tick that arrives while a pass is in progress is ignored.
- R10: `out_valid` is high for exactly one cycle, at edge k+NUM_VOICES+1 for a tick accepted at edge k. `out_left` and `out_right` change only at that edge and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Output-sample strobe that starts a pass |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 8 | Register write address |
| reg_wdata | input | 16 | Register write data |
| mem_rd | output | 1 | Sample fetch strobe |
| mem_addr | output | 16 | Sample address (integer position) |
| mem_bank | output | 8 | Sample bank |
| mem_data | input | 8 | Sample returned in the fetch cycle |
| out_left | output | 16 | Left mix, upper half of the 32-bit sum |
| out_right | output | 16 | Right mix, upper half of the 32-bit sum |
| out_valid | output | 1 | One-cycle strobe when the outputs update |

## Verification
A wrong position, limit or loop value in one voice shows up on `mem_addr` at that voice's slot in the next pass. That is no later than one tick period after the error arises, so the bench compares every fetch address and bank against its own model. Errors in the sign extension, the volume product or the accumulator reach `out_left` and `out_right` at the end of the same pass. Random signed volumes and data from a computed sample memory make such errors show up on almost every tick. A sequencing fault, such as a lost slot, a fetch from a stopped voice, a re-triggered pass or a misplaced strobe, moves `mem_rd` or `out_valid` by at least one cycle against the fixed slot timing. The bench checks that timing on every cycle of every pass.

// File: rtl/pcm_mix_pkg.sv
package pcm_mix_pkg;

  // Fixed field offsets; software and the voice decode depend on them.
  localparam logic [7:0] POS_BASE  = 8'h00;
  localparam logic [7:0] RATE_BASE = 8'h16;
  localparam logic [7:0] LIM_BASE  = 8'h21;
  localparam logic [7:0] LOOP_BASE = 8'h2C;
  localparam logic [7:0] BANK_BASE = 8'h37;
  localparam logic [7:0] VOLR_BASE = 8'h42;
  localparam logic [7:0] VOLL_BASE = 8'h4D;
  localparam int unsigned MAP_SLOTS = 11;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

endpackage

// File: rtl/pcm_mix_regfile.sv
module pcm_mix_regfile
  import pcm_mix_pkg::*;
#(
  parameter int NUM_VOICES = 11,
  parameter int ADDR_W     = 16,
  parameter int FRAC_W     = 8,
  parameter int RATE_W     = 16,
  parameter int BANK_W     = 8,
  parameter int VOL_W      = 16,
  parameter int DATA_W     = 16,
  parameter int IDX_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [IDX_W-1:0]  sel,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] upd_int,
  input  logic [FRAC_W-1:0] upd_frac,
  output logic [ADDR_W-1:0] sel_int,
  output logic [FRAC_W-1:0] sel_frac,
  output logic [RATE_W-1:0] sel_rate,
  output logic [ADDR_W-1:0] sel_lim,
  output logic [ADDR_W-1:0] sel_loop,
  output logic [BANK_W-1:0] sel_bank,
  output logic [VOL_W-1:0]  sel_voll,
  output logic [VOL_W-1:0]  sel_volr
);

  localparam int SLOTS = 1 << IDX_W;

  logic [ADDR_W-1:0] int_a  [SLOTS];
  logic [FRAC_W-1:0] frac_a [SLOTS];
  logic [RATE_W-1:0] rate_a [SLOTS];
  logic [ADDR_W-1:0] lim_a  [SLOTS];
  logic [ADDR_W-1:0] loop_a [SLOTS];
  logic [BANK_W-1:0] bank_a [SLOTS];
  logic [VOL_W-1:0]  voll_a [SLOTS];
  logic [VOL_W-1:0]  volr_a [SLOTS];

  for (genvar v = 0; v < SLOTS; v++) begin : g_slot
    if (v < NUM_VOICES) begin : g_voice
      localparam logic [7:0] A_POS  = POS_BASE  + 8'(v);
      localparam logic [7:0] A_RATE = RATE_BASE + 8'(v);
      localparam logic [7:0] A_LIM  = LIM_BASE  + 8'(v);
      localparam logic [7:0] A_LOOP = LOOP_BASE + 8'(v);
      localparam logic [7:0] A_BANK = BANK_BASE + 8'(v);
      localparam logic [7:0] A_VOLR = VOLR_BASE + 8'(v);
      localparam logic [7:0] A_VOLL = VOLL_BASE + 8'(v);

      logic              pos_en, cfg_en;
      logic [ADDR_W-1:0] int_q, int_d, lim_q, lim_d, loop_q, loop_d;
      logic [FRAC_W-1:0] frac_q, frac_d;
      logic [RATE_W-1:0] rate_q, rate_d;
      logic [BANK_W-1:0] bank_q, bank_d;
      logic [VOL_W-1:0]  voll_q, voll_d, volr_q, volr_d;

      always_comb begin
        int_d  = int_q;
        frac_d = frac_q;
        rate_d = rate_q;
        lim_d  = lim_q;
        loop_d = loop_q;
        bank_d = bank_q;
        voll_d = voll_q;
        volr_d = volr_q;
        // a software position write wins over the engine's step
        if (reg_we && (reg_addr == A_POS)) begin
          int_d  = reg_wdata[ADDR_W-1:0];
          frac_d = '0;
        end else if (upd_en && (sel == IDX_W'(v))) begin
          int_d  = upd_int;
          frac_d = upd_frac;
        end
        if (reg_we && (reg_addr == A_RATE)) rate_d = reg_wdata[RATE_W-1:0];
        if (reg_we && (reg_addr == A_LIM))  lim_d  = reg_wdata[ADDR_W-1:0];
        if (reg_we && (reg_addr == A_LOOP)) loop_d = reg_wdata[ADDR_W-1:0];
        if (reg_we && (reg_addr == A_BANK)) bank_d = reg_wdata[BANK_W-1:0];
        if (reg_we && (reg_addr == A_VOLL)) voll_d = reg_wdata[VOL_W-1:0];
        if (reg_we && (reg_addr == A_VOLR)) volr_d = reg_wdata[VOL_W-1:0];
      end

      assign pos_en = reg_we || (upd_en && (sel == IDX_W'(v)));
      assign cfg_en = reg_we;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          int_q  <= '0;
          frac_q <= '0;
        end else if (pos_en) begin
          int_q  <= int_d;
          frac_q <= frac_d;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rate_q <= '0;
          lim_q  <= '0;
          loop_q <= '0;
          bank_q <= '0;
          voll_q <= '0;
          volr_q <= '0;
        end else if (cfg_en) begin
          rate_q <= rate_d;
          lim_q  <= lim_d;
          loop_q <= loop_d;
          bank_q <= bank_d;
          voll_q <= voll_d;
          volr_q <= volr_d;
        end
      end

      assign int_a[v]  = int_q;
      assign frac_a[v] = frac_q;
      assign rate_a[v] = rate_q;
      assign lim_a[v]  = lim_q;
      assign loop_a[v] = loop_q;
      assign bank_a[v] = bank_q;
      assign voll_a[v] = voll_q;
      assign volr_a[v] = volr_q;
    end else begin : g_pad
      assign int_a[v]  = '0;
      assign frac_a[v] = '0;
      assign rate_a[v] = '0;
      assign lim_a[v]  = '0;
      assign loop_a[v] = '0;
      assign bank_a[v] = '0;
      assign voll_a[v] = '0;
      assign volr_a[v] = '0;
    end
  end

  assign sel_int  = int_a[sel];
  assign sel_frac = frac_a[sel];
  assign sel_rate = rate_a[sel];
  assign sel_lim  = lim_a[sel];
  assign sel_loop = loop_a[sel];
  assign sel_bank = bank_a[sel];
  assign sel_voll = voll_a[sel];
  assign sel_volr = volr_a[sel];

endmodule

// File: rtl/pcm_mix_step.sv
module pcm_mix_step #(
  parameter int ADDR_W = 16,
  parameter int FRAC_W = 8,
  parameter int RATE_W = 16
) (
  input  logic [ADDR_W-1:0] pos_int,
  input  logic [FRAC_W-1:0] pos_frac,
  input  logic [RATE_W-1:0] rate,
  input  logic [ADDR_W-1:0] limit,
  input  logic [ADDR_W-1:0] loop_start,
  output logic [ADDR_W-1:0] nxt_int,
  output logic [FRAC_W-1:0] nxt_frac
);

  localparam int POS_W = ADDR_W + FRAC_W;

  logic [POS_W:0]  sum;
  logic [ADDR_W:0] sum_int;
  logic            wrap;

  always_comb begin
    sum      = {1'b0, pos_int, pos_frac} + (POS_W + 1)'(rate);
    sum_int  = sum[POS_W:FRAC_W];
    // the carry bit takes part, so a step past the top always wraps
    wrap     = (sum_int >= {1'b0, limit});
    nxt_int  = wrap ? loop_start : sum_int[ADDR_W-1:0];
    nxt_frac = sum[FRAC_W-1:0];
  end

endmodule

// File: rtl/pcm_mix_seq.sv
module pcm_mix_seq
  import pcm_mix_pkg::*;
#(
  parameter int NUM_VOICES = 11,
  parameter int IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [IDX_W-1:0] idx,
  output logic             run,
  output logic             clr,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_VOICES - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    clr     = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (tick) begin
          state_d = SEQ_RUN;
          idx_d   = '0;
          clr     = 1'b1;
        end
      end
      SEQ_RUN: begin
        if (idx_q == LAST) state_d = SEQ_DONE;
        else               idx_d   = idx_q + 1'b1;
      end
      SEQ_DONE: state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign idx  = idx_q;
  assign run  = (state_q == SEQ_RUN);
  assign done = (state_q == SEQ_DONE);

endmodule

// File: rtl/pcm_mix_mac.sv
module pcm_mix_mac #(
  parameter int SAMP_W = 8,
  parameter int VOL_W  = 16,
  parameter int ACC_W  = 32,
  parameter int OUT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic              done,
  input  logic [SAMP_W-1:0] sample,
  input  logic [VOL_W-1:0]  vol_l,
  input  logic [VOL_W-1:0]  vol_r,
  output logic [OUT_W-1:0]  out_left,
  output logic [OUT_W-1:0]  out_right,
  output logic              out_valid
);

  localparam int PROD_W = SAMP_W + VOL_W;

  logic signed [PROD_W-1:0] smp_x, vl_x, vr_x, prod_l, prod_r;
  logic [ACC_W-1:0] acc_l_q, acc_l_d, acc_r_q, acc_r_d;
  logic [OUT_W-1:0] out_l_q, out_r_q;
  logic             valid_q;

  always_comb begin
    smp_x  = {{VOL_W{sample[SAMP_W-1]}}, sample};
    vl_x   = {{SAMP_W{vol_l[VOL_W-1]}}, vol_l};
    vr_x   = {{SAMP_W{vol_r[VOL_W-1]}}, vol_r};
    prod_l = smp_x * vl_x;
    prod_r = smp_x * vr_x;
    acc_l_d = acc_l_q;
    acc_r_d = acc_r_q;
    if (clr) begin
      acc_l_d = '0;
      acc_r_d = '0;
    end else if (en) begin
      acc_l_d = acc_l_q + {{(ACC_W-PROD_W){prod_l[PROD_W-1]}}, prod_l};
      acc_r_d = acc_r_q + {{(ACC_W-PROD_W){prod_r[PROD_W-1]}}, prod_r};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_l_q <= '0;
      acc_r_q <= '0;
    end else if (clr || en) begin
      acc_l_q <= acc_l_d;
      acc_r_q <= acc_r_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_l_q <= '0;
      out_r_q <= '0;
    end else if (done) begin
      out_l_q <= acc_l_q[ACC_W-1:ACC_W-OUT_W];
      out_r_q <= acc_r_q[ACC_W-1:ACC_W-OUT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= done;
  end

  assign out_left  = out_l_q;
  assign out_right = out_r_q;
  assign out_valid = valid_q;

endmodule

// File: rtl/pcm_voice_mixer.sv
module pcm_voice_mixer
  import pcm_mix_pkg::*;
#(
  parameter int NUM_VOICES = 11,
  parameter int ADDR_W     = 16,
  parameter int FRAC_W     = 8,
  parameter int RATE_W     = 16,
  parameter int BANK_W     = 8,
  parameter int VOL_W      = 16,
  parameter int SAMP_W     = 8,
  parameter int DATA_W     = 16,
  parameter int ACC_W      = 32,
  parameter int OUT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BANK_W-1:0] mem_bank,
  input  logic [SAMP_W-1:0] mem_data,
  output logic [OUT_W-1:0]  out_left,
  output logic [OUT_W-1:0]  out_right,
  output logic              out_valid
);

  localparam int IDX_W = $clog2(NUM_VOICES);

  initial begin
    if (NUM_VOICES < 2 || NUM_VOICES > MAP_SLOTS)
      $error("NUM_VOICES must lie between 2 and the register map capacity");
  end

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic [IDX_W-1:0]  idx;
  logic              run, clr, done, active;
  logic [ADDR_W-1:0] sel_int, sel_lim, sel_loop, upd_int;
  logic [FRAC_W-1:0] sel_frac, upd_frac;
  logic [RATE_W-1:0] sel_rate;
  logic [BANK_W-1:0] sel_bank;
  logic [VOL_W-1:0]  sel_voll, sel_volr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  pcm_mix_seq #(
    .NUM_VOICES(NUM_VOICES), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick),
    .idx(idx), .run(run), .clr(clr), .done(done)
  );

  pcm_mix_regfile #(
    .NUM_VOICES(NUM_VOICES), .ADDR_W(ADDR_W), .FRAC_W(FRAC_W),
    .RATE_W(RATE_W), .BANK_W(BANK_W), .VOL_W(VOL_W),
    .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .sel(idx), .upd_en(mem_rd), .upd_int(upd_int), .upd_frac(upd_frac),
    .sel_int(sel_int), .sel_frac(sel_frac), .sel_rate(sel_rate),
    .sel_lim(sel_lim), .sel_loop(sel_loop), .sel_bank(sel_bank),
    .sel_voll(sel_voll), .sel_volr(sel_volr)
  );

  pcm_mix_step #(
    .ADDR_W(ADDR_W), .FRAC_W(FRAC_W), .RATE_W(RATE_W)
  ) u_step (
    .pos_int(sel_int), .pos_frac(sel_frac), .rate(sel_rate),
    .limit(sel_lim), .loop_start(sel_loop),
    .nxt_int(upd_int), .nxt_frac(upd_frac)
  );

  assign active   = (sel_voll != '0) || (sel_volr != '0);
  assign mem_rd   = run && active;
  assign mem_addr = sel_int;
  assign mem_bank = sel_bank;

  pcm_mix_mac #(
    .SAMP_W(SAMP_W), .VOL_W(VOL_W), .ACC_W(ACC_W), .OUT_W(OUT_W)
  ) u_mac (
    .clk(clk), .rst_n(rst_sync_n), .clr(clr), .en(mem_rd), .done(done),
    .sample(mem_data), .vol_l(sel_voll), .vol_r(sel_volr),
    .out_left(out_left), .out_right(out_right), .out_valid(out_valid)
  );

endmodule

// File: rtl/pcm_mix_chk.sv
module pcm_mix_chk #(
  parameter int NUM_VOICES = 11,
  parameter int ADDR_W     = 16,
  parameter int OUT_W      = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic [OUT_W-1:0]  out_left,
  input logic [OUT_W-1:0]  out_right,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] upd_int,
  input logic [ADDR_W-1:0] sel_lim,
  input logic [ADDR_W-1:0] sel_loop
);

  logic [7:0] fetch_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fetch_cnt_q <= '0;
    else if (out_valid) fetch_cnt_q <= {7'd0, mem_rd};
    else if (mem_rd)    fetch_cnt_q <= fetch_cnt_q + 8'd1;
  end

  // R1: first cycle after reset release is quiet
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && !mem_rd && out_left == '0 && out_right == '0));

  // R10: output strobe lasts one cycle
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R10: outputs hold unless the strobe marks a new value
  p_hold_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_left) && $stable(out_right)));

  // R3: never more fetches in a pass than there are voices
  p_fetch_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_cnt_q <= 8'(NUM_VOICES));

  // R6: a stepped position is below the limit or sits at the loop start
  p_wrap_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> ((upd_int < sel_lim) || (upd_int == sel_loop)));

endmodule

bind pcm_voice_mixer pcm_mix_chk #(
  .NUM_VOICES(NUM_VOICES), .ADDR_W(ADDR_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .out_valid(out_valid),
  .out_left(out_left), .out_right(out_right), .mem_rd(mem_rd),
  .upd_int(upd_int), .sel_lim(sel_lim), .sel_loop(sel_loop)
);

// File: tb/pcm_voice_mixer_tb.sv
module pcm_voice_mixer_tb;

  localparam int NV = 11;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_bank;
  logic [7:0]  mem_data;
  logic [15:0] out_left, out_right;
  logic        out_valid;

  int n_vec = 0;
  int n_bad = 0;

  // model state
  int                 m_int[NV], m_frac[NV], m_rate[NV], m_lim[NV], m_loop[NV], m_bank[NV];
  logic signed [15:0] m_vl[NV], m_vr[NV];
  logic [15:0]        last_l, last_r;

  always #10 clk = ~clk;

  pcm_voice_mixer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_bank(mem_bank), .mem_data(mem_data),
    .out_left(out_left), .out_right(out_right), .out_valid(out_valid)
  );

  function automatic logic [7:0] memf(input logic [15:0] a, input logic [7:0] b);
    logic [15:0] t;
    t = a * 16'd3 + {8'd0, a[15:8]} * 16'd7 + {8'd0, b} * 16'd53 + 16'd17;
    return t[7:0];
  endfunction

  assign mem_data = memf(mem_addr, mem_bank);

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_we = 1'b0;
    for (int v = 0; v < NV; v++) begin
      if (a == 'h00 + v) begin m_int[v] = d & 'hFFFF; m_frac[v] = 0; end
      if (a == 'h16 + v) m_rate[v] = d & 'hFFFF;
      if (a == 'h21 + v) m_lim[v]  = d & 'hFFFF;
      if (a == 'h2C + v) m_loop[v] = d & 'hFFFF;
      if (a == 'h37 + v) m_bank[v] = d & 'hFF;
      if (a == 'h42 + v) m_vr[v]   = 16'(d);
      if (a == 'h4D + v) m_vl[v]   = 16'(d);
    end
  endtask

  task automatic run_tick(input string tag, input bit poke_busy);
    int          accl, accr, s, sum;
    bit          act;
    logic [31:0] tl, tr;
    accl = 0; accr = 0;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    for (int v = 0; v < NV; v++) begin
      tick = (poke_busy && v == 2);
      act = (m_vl[v] != 0) || (m_vr[v] != 0);
      chk(act ? "R3" : "R7", $sformatf("%s mem_rd slot %0d", tag, v), longint'(mem_rd), longint'(act));
      if (act) begin
        chk(tag, $sformatf("mem_addr R3 slot %0d", v), longint'(mem_addr), longint'(m_int[v]));
        chk("R3", $sformatf("mem_bank slot %0d", v), longint'(mem_bank), longint'(m_bank[v]));
        s = int'($signed(memf(16'(m_int[v]), 8'(m_bank[v]))));
        accl += s * int'(m_vl[v]);
        accr += s * int'(m_vr[v]);
        sum = m_int[v] * 256 + m_frac[v] + m_rate[v];
        m_frac[v] = sum & 'hFF;
        if ((sum >> 8) >= m_lim[v]) m_int[v] = m_loop[v];
        else                        m_int[v] = sum >> 8;
      end
      @(negedge clk);
    end
    tick = 1'b0;
    chk("R10", "out_valid before end of pass", longint'(out_valid), 0);
    chk("R10", "outputs held during pass", longint'({out_left, out_right}), longint'({last_l, last_r}));
    @(negedge clk);
    tl = 32'(accl); tr = 32'(accr);
    chk("R10", "out_valid at pass end", longint'(out_valid), 1);
    chk("R4", $sformatf("%s out_left", tag), longint'(out_left), longint'(tl[31:16]));
    chk("R4", $sformatf("%s out_right", tag), longint'(out_right), longint'(tr[31:16]));
    last_l = tl[31:16]; last_r = tr[31:16];
    @(negedge clk);
    chk("R10", "out_valid one cycle", longint'(out_valid), 0);
    chk("R10", "outputs hold after strobe", longint'({out_left, out_right}), longint'({last_l, last_r}));
    if (poke_busy) begin
      bit quiet;
      quiet = 1'b1;
      repeat (NV + 3) begin
        @(negedge clk);
        if (mem_rd !== 1'b0 || out_valid !== 1'b0) quiet = 1'b0;
      end
      chk("R9", "no second pass from busy tick", longint'(quiet), 1);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    int rb[7];
    rb = '{'h00, 'h16, 'h21, 'h2C, 'h37, 'h42, 'h4D};
    for (int v = 0; v < NV; v++) begin
      m_int[v] = 0; m_frac[v] = 0; m_rate[v] = 0; m_lim[v] = 0;
      m_loop[v] = 0; m_bank[v] = 0; m_vl[v] = 0; m_vr[v] = 0;
    end
    last_l = '0; last_r = '0;
    rst_n = 1'b0; tick = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", longint'({out_left, out_right}), 0);
    chk("R1", "strobes in reset", longint'({out_valid, mem_rd}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "outputs after release", longint'({out_valid, mem_rd, out_left, out_right}), 0);

    // all voices silent after reset
    run_tick("R7", 1'b0);

    // step and wrap on voice 0: 10 -> 11.5 -> 13.0 -> 14.5 wraps to 11.5 -> 13.0
    wr('h00, 10); wr('h16, 'h0180); wr('h21, 14); wr('h2C, 11);
    wr('h4D, 'h1000); wr('h42, 'hF000); wr('h37, 3);
    run_tick("R5", 1'b0); run_tick("R5", 1'b0); run_tick("R5", 1'b0);
    run_tick("R6", 1'b0); run_tick("R6", 1'b0);

    // position write clears the fraction
    wr('h00, 'h20);
    run_tick("R8", 1'b0); run_tick("R8", 1'b0); run_tick("R8", 1'b0);

    // carry past the 16-bit integer forces a wrap
    wr('h01, 'hFFF0); wr('h17, 'hFF00); wr('h22, 'hFFFF); wr('h2D, 'h0100);
    wr('h4E, 'h7FFF); wr('h43, 'h8000); wr('h38, 'h55);
    run_tick("R6", 1'b0); run_tick("R6", 1'b0);

    // writes to unmapped addresses change nothing
    for (int a = 'h0B; a <= 'h15; a++) wr(a, 'hA5A5 ^ a);
    for (int a = 'h58; a <= 'h60; a++) wr(a, 'h5A5A + a);
    wr('hFF, 'h1234);
    run_tick("R2", 1'b0); run_tick("R2", 1'b0);

    // tick while busy
    run_tick("R9", 1'b1);

    // freeze: silence voice 0, run, then re-enable and expect same position
    wr('h4D, 0); wr('h42, 0);
    run_tick("R7", 1'b0); run_tick("R7", 1'b0);
    wr('h4D, 'h0400);
    run_tick("R7", 1'b0);

    // full configuration of every voice through the map, then random updates
    for (int v = 0; v < NV; v++) begin
      wr('h00 + v, $urandom_range(0, 'hFFFF));
      wr('h16 + v, $urandom_range(0, 'h3FF));
      wr('h21 + v, $urandom_range(0, 'hFFFF));
      wr('h2C + v, $urandom_range(0, 'hFFFF));
      wr('h37 + v, $urandom_range(0, 'hFF));
      wr('h42 + v, $urandom_range(0, 'hFFFF));
      wr('h4D + v, $urandom_range(0, 'hFFFF));
    end
    run_tick("R2", 1'b0);
    for (int r = 0; r < 60; r++) begin
      for (int k = 0; k < 4; k++) begin
        int f, v, d;
        f = $urandom_range(0, 6);
        v = $urandom_range(0, NV - 1);
        d = $urandom_range(0, 'hFFFF);
        if (f == 2 && ($urandom_range(0, 1) == 1)) d = $urandom_range(0, 'h40);
        if (f >= 5 && ($urandom_range(0, 3) == 0)) d = 0;
        wr(rb[f] + v, d);
      end
      run_tick("R4", 1'b0); run_tick("R5", 1'b0); run_tick("R6", 1'b0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule